// File: doc/BRIEF.md
# Battery-Backed Byte-Wide SRAM Controller

This block models a byte-wide static RAM with active-low chip select, output enable and write enable. It is clocked by a sampling clock that runs much faster than the strobe rate. The data bus is split into a write-data input, a read-data output and a driver-enable output. The pad logic around the block builds the real bidirectional pins from these three signals. A deselect input from a supply monitor forces the block off whenever the supply is out of range.

The block decodes the operating state from the three strobes. It drives the addressed byte out during a read. A write is committed only when its window closes. The window opens once chip select and write enable have both been seen low, whichever of the two fell last. It closes at the first sample in which either of them is seen high again. The byte stored is the write data present at that closing sample.

The address width is a parameter. A full 32 K x 8 part uses 15 bits; the default of 12 keeps elaboration small. Reset clears only the strobe history. The storage keeps its contents through reset, as the battery-backed array does through a supply outage.

Top module: `bbsram_ctrl`

## Requirements
- R1: With the supply deselect low, chip select low, output enable low and write enable high, `dout_en` is 1. In the same cycle, `dout` shows the byte last stored at `addr`.
- R2: While chip select is high, `dout_en` is 0. A write-enable pulse given while chip select stays high stores nothing.
- R3: With chip select low and both output enable and write enable high, `dout_en` is 0.
- R4: Whenever chip select and write enable are both low, `dout_en` is 0, whatever the output enable does. This holds when the block was driving just before. It also holds when both strobes fall in the same cycle, in which case the outputs never turn on.
- R5: A write stores `din` into `addr` at the first rising clock edge at which chip select or write enable is sampled high, after an earlier edge at which both were sampled low. Values of `din` before that closing edge are not stored. The byte is readable from the next cycle.
- R6: A write framed by chip select also stores its byte. In this case write enable falls first with chip select high, and chip select then pulses low.
- R7: While the supply deselect is high, `dout_en` is 0 and every strobe is ignored, so no byte is stored.
- R8: If the supply deselect rises during an open write window, that write is discarded. If the deselect then falls while both strobes are still low, no new window opens until a strobe has been seen high. No other address changes.
- R9: Reset does not alter the stored bytes.
- R10: Whenever `dout_en` is 0, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset of the strobe history |
| ce_n | input | 1 | Chip select, active low, already synchronized |
| oe_n | input | 1 | Output enable, active low, already synchronized |
| we_n | input | 1 | Write enable, active low, already synchronized |
| pf_desel | input | 1 | Supply-fail deselect, active high, overrides all strobes |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the pad |
| dout | output | DATA_W | Read data to the pad, zero when not driving |
| dout_en | output | 1 | Pad driver enable |

## Verification
The bench targets four corner cases.

- **Write-data timing.** Junk is placed on `din` while the window is open and the real byte is placed there only at the closing sample. A design that latched data on the opening edge would store the junk.
- **Strobe collisions.** Write enable is dropped during an active read, and both strobes fall together from idle. A decode that gave output enable priority over write enable would turn the drivers on against incoming data.
- **Supply deselect mid-write.** The deselect is raised in the middle of a write, and in a second case it is released while both strobes are still low. A design that re-armed on level instead of edge would store a byte the host never framed. A design that let the deselect smear into the array would corrupt a neighbouring address.
- **Reset.** A read-back follows a reset. It catches storage that was wrongly placed under reset.

// File: rtl/bbsram_pkg.sv
// Package: shared operating-state encoding for the byte-wide SRAM controller.
// Assumes: nothing; pure type definitions.
package bbsram_pkg;

    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,  // supply deselect active
        MODE_DESEL = 3'd1,  // chip select high
        MODE_IDLE  = 3'd2,  // selected, no read, no write
        MODE_READ  = 3'd3,  // selected, driving data
        MODE_WRITE = 3'd4   // selected, write strobe low
    } bbs_mode_e;

endpackage

// File: rtl/bbsram_mode_dec.sv
// Module: bbsram_mode_dec
// Decodes the operating state from the strobes.
// Priority: supply deselect first, then chip select, then write enable, then output enable.
// Assumes: strobes are synchronous to the sampling clock; purely combinational.
module bbsram_mode_dec
    import bbsram_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      pf_desel,
    output bbs_mode_e mode
);

    // Priority decode of the strobe combination.
    always_comb begin
        if (pf_desel) begin
            mode = MODE_OFF;
        end else if (ce_n) begin
            mode = MODE_DESEL;
        end else if (!we_n) begin
            mode = MODE_WRITE;
        end else if (!oe_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_IDLE;
        end
    end

endmodule

// File: rtl/bbsram_wr_window.sv
// Module: bbsram_wr_window
// Tracks the write window bounded by the later falling edge and the earlier
// rising edge of chip select and write enable.
// Emits a one-cycle commit at the closing edge.
// Edges are found by comparing each strobe with its registered copy.
// The window opens only on a fresh fall, never on a level that survives the
// end of a supply deselect.
// Assumes: strobes are already synchronized; the address is held stable until the commit.
module bbsram_wr_window (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic pf_desel,
    output logic wr_commit
);

    logic ce_q;
    logic we_q;
    logic wr_open_q;
    logic both_low_now;
    logic both_low_prev;
    logic wr_active;
    logic wr_open_d;

    // Current and previous "both strobes low" conditions.
    always_comb begin
        both_low_now  = !ce_n && !we_n;
        both_low_prev = !ce_q && !we_q;
        wr_active     = both_low_now && !pf_desel;
    end

    // Window stays open while active; it opens only when the previous sample was not both-low.
    always_comb begin
        wr_open_d = wr_active && (wr_open_q || !both_low_prev);
    end

    // Commit when an open window sees either strobe high and the supply is good.
    always_comb begin
        wr_commit = wr_open_q && (ce_n || we_n) && !pf_desel;
    end

    // Register strobe copies and the window state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q      <= 1'b1;
            we_q      <= 1'b1;
            wr_open_q <= 1'b0;
        end else begin
            ce_q      <= ce_n;
            we_q      <= we_n;
            wr_open_q <= wr_open_d;
        end
    end

endmodule

// File: rtl/bbsram_array.sv
// Module: bbsram_array
// Byte storage with one synchronous write port and a combinational read port.
// Assumes: contents are retained through reset (battery-backed), so the storage has no reset.
module bbsram_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the byte on a commit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // Ripple-through read of the addressed byte.
    always_comb begin
        rdata = mem[addr];
    end

endmodule

// File: rtl/bbsram_out_drv.sv
// Module: bbsram_out_drv
// Drives the pad data and driver enable from the decoded state.
// The data output is zeroed whenever the drivers are off.
// Assumes: the pad cell builds the real three-state pin from dout and dout_en.
module bbsram_out_drv
    import bbsram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bbs_mode_e         mode,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    // Enable the drivers only in the read state.
    always_comb begin
        dout_en = (mode == MODE_READ);
        dout    = dout_en ? rdata : '0;
    end

endmodule

// File: rtl/bbsram_ctrl.sv
// Module: bbsram_ctrl (top)
// Byte-wide SRAM with chip select, output enable and write enable.
// Writes are framed by the strobe edges; a supply-fail deselect overrides every strobe.
// Assumes: strobes are synchronized to clk, which samples much faster than the strobe rate.
module bbsram_ctrl
    import bbsram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              pf_desel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    bbs_mode_e         mode;
    logic              wr_commit;
    logic [DATA_W-1:0] rdata;

    bbsram_mode_dec i_mode_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .pf_desel (pf_desel),
        .mode     (mode)
    );

    bbsram_wr_window i_wr_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .pf_desel  (pf_desel),
        .wr_commit (wr_commit)
    );

    bbsram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_array (
        .clk   (clk),
        .wr_en (wr_commit),
        .addr  (addr),
        .wdata (din),
        .rdata (rdata)
    );

    bbsram_out_drv #(
        .DATA_W (DATA_W)
    ) i_out_drv (
        .mode    (mode),
        .rdata   (rdata),
        .dout    (dout),
        .dout_en (dout_en)
    );

endmodule

// File: rtl/bbsram_ctrl_chk.sv
// Module: bbsram_ctrl_chk
// Property checker for bbsram_ctrl, attached by bind.
// Assumes: the top-level strobes and the internal commit pulse are visible in the bound scope.
module bbsram_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              pf_desel,
    input logic              dout_en,
    input logic              wr_commit,
    input logic [DATA_W-1:0] dout
);

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_desel && !ce_n && !oe_n && we_n) |-> dout_en); // R1

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !dout_en); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && we_n) |-> !dout_en); // R3

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> !dout_en); // R4

    AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(!ce_n && !we_n && !pf_desel)); // R5

    AST_COMMIT_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (ce_n || we_n)); // R5

    AST_PF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pf_desel |-> !dout_en); // R7

    AST_PF_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pf_desel |-> !wr_commit); // R8

    AST_DOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R10

endmodule

bind bbsram_ctrl bbsram_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .pf_desel  (pf_desel),
    .dout_en   (dout_en),
    .wr_commit (wr_commit),
    .dout      (dout)
);

// File: tb/test_bbsram_ctrl.sv
// Bench for bbsram_ctrl.
// Directed corner cases plus seeded random transactions, checked against a bench-side byte model.
module test_bbsram_ctrl;

    localparam int AW    = 12;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk      = 1'b0;
    logic          rst_n    = 1'b0;
    logic          ce_n     = 1'b1;
    logic          oe_n     = 1'b1;
    logic          we_n     = 1'b1;
    logic          pf_desel = 1'b0;
    logic [AW-1:0] addr     = '0;
    logic [DW-1:0] din      = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int            checks   = 0;
    int            fails    = 0;
    logic [DW-1:0] model [DEPTH];
    bit            valid [DEPTH];

    always #4 clk = ~clk;

    bbsram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_bbsram_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pf_desel(pf_desel), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // Expected driver enable, taken from R1-style decode rules.
    function automatic logic exp_en(logic c, logic o, logic w, logic p);
        return !p && !c && !o && w;
    endfunction

    // Requirement label that governs the enable for a strobe combination.
    function automatic string en_req(logic c, logic o, logic w, logic p);
        if (p) return "R7";
        if (c) return "R2";
        if (!w) return "R4";
        if (o) return "R3";
        return "R1";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one sample period and check the enable and the zeroed output away from the clock edge.
    task automatic cyc(logic c, logic o, logic w, logic p, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; pf_desel = p; addr = a; din = d;
        #1;
        chk(en_req(c, o, w, p), {31'd0, dout_en}, {31'd0, exp_en(c, o, w, p)});
        if (!exp_en(c, o, w, p)) chk("R10", {24'd0, dout}, 32'd0);
    endtask

    task automatic idle();
        cyc(1, 1, 1, 0, addr, din);
    endtask

    task automatic rd(logic [AW-1:0] a, string req);
        cyc(0, 0, 1, 0, a, 8'h00);
        if (valid[a]) chk(req, {24'd0, dout}, {24'd0, model[a]});
        idle();
    endtask

    // Write framed by write enable, chip select held low; junk on din until the close.
    task automatic wr_w(logic [AW-1:0] a, logic [DW-1:0] junk, logic [DW-1:0] d);
        cyc(0, 1, 1, 0, a, junk);
        cyc(0, 1, 0, 0, a, junk);
        cyc(0, 0, 0, 0, a, junk);
        cyc(0, 1, 1, 0, a, d);
        model[a] = d; valid[a] = 1'b1;
        idle();
    endtask

    // Write framed by chip select; write enable falls first.
    task automatic wr_e(logic [AW-1:0] a, logic [DW-1:0] junk, logic [DW-1:0] d);
        cyc(1, 1, 0, 0, a, junk);
        cyc(0, 1, 0, 0, a, junk);
        cyc(1, 1, 0, 0, a, d);
        model[a] = d; valid[a] = 1'b1;
        idle();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) valid[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: drivers off.
        idle();
        chk("R2", {31'd0, dout_en}, 32'd0);

        // R5: write-enable framed write, junk before the close is not stored.
        wr_w(12'h010, 8'hFF, 8'h3C);
        rd(12'h010, "R5");
        wr_w(12'h011, 8'h00, 8'h5A);
        rd(12'h011, "R5");

        // R6: chip-select framed write.
        wr_e(12'h020, 8'h11, 8'hA7);
        rd(12'h020, "R6");

        // R2: write strobe with chip select high stores nothing.
        cyc(1, 1, 0, 0, 12'h010, 8'h99);
        cyc(1, 1, 1, 0, 12'h010, 8'h99);
        rd(12'h010, "R2");

        // R4: write enable dropped during a read turns drivers off, then commits.
        cyc(0, 0, 1, 0, 12'h030, 8'h00);
        cyc(0, 0, 0, 0, 12'h030, 8'h42);
        chk("R4", {31'd0, dout_en}, 32'd0);
        cyc(0, 0, 1, 0, 12'h030, 8'h42);
        model[12'h030] = 8'h42; valid[12'h030] = 1'b1;
        idle();
        rd(12'h030, "R4");

        // R4: both strobes fall together with output enable low.
        cyc(1, 0, 1, 0, 12'h031, 8'h00);
        cyc(0, 0, 0, 0, 12'h031, 8'h77);
        chk("R4", {31'd0, dout_en}, 32'd0);
        cyc(1, 0, 1, 0, 12'h031, 8'h77);
        model[12'h031] = 8'h77; valid[12'h031] = 1'b1;
        rd(12'h031, "R4");

        // R7: read strobes under deselect are ignored; a full write under deselect stores nothing.
        cyc(0, 0, 1, 1, 12'h010, 8'h00);
        chk("R7", {31'd0, dout_en}, 32'd0);
        cyc(1, 1, 0, 1, 12'h010, 8'hE1);
        cyc(0, 1, 0, 1, 12'h010, 8'hE1);
        cyc(1, 1, 0, 1, 12'h010, 8'hE1);
        cyc(1, 1, 1, 1, 12'h010, 8'hE1);
        idle();
        rd(12'h010, "R7");

        // R8: deselect rises mid-window; write discarded, neighbour intact.
        cyc(0, 1, 0, 0, 12'h010, 8'hD0);
        cyc(0, 1, 0, 1, 12'h010, 8'hD0);
        cyc(1, 1, 1, 1, 12'h010, 8'hD0);
        idle();
        rd(12'h010, "R8");
        rd(12'h011, "R8");

        // R8: deselect released while both strobes remain low; no fresh window.
        cyc(0, 1, 0, 0, 12'h010, 8'hEE);
        cyc(0, 1, 0, 1, 12'h010, 8'hEE);
        cyc(0, 1, 0, 0, 12'h010, 8'hEE);
        cyc(0, 1, 1, 0, 12'h010, 8'hEE);
        idle();
        rd(12'h010, "R8");

        // R9: reset keeps stored bytes.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(12'h010, "R9");
        rd(12'h020, "R9");

        // Seeded random transactions.
        for (int n = 0; n < 400; n++) begin
            automatic int            op = $urandom_range(0, 4);
            automatic logic [AW-1:0] a  = AW'($urandom_range(0, DEPTH - 1));
            automatic logic [DW-1:0] d  = DW'($urandom);
            automatic logic [DW-1:0] j  = DW'($urandom);
            case (op)
                0: rd(a, "R1");
                1: wr_w(a, j, d);
                2: wr_e(a, j, d);
                3: begin
                    cyc(1, 0, 0, 0, a, d);
                    cyc(1, 0, 1, 0, a, d);
                    rd(a, "R2");
                end
                default: begin
                    cyc(0, 1, 0, 1, a, d);
                    cyc(1, 1, 1, 1, a, d);
                    idle();
                    rd(a, "R7");
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule